// File: doc/BRIEF.md
# Multi-Region External Bus Controller

This block turns single read and write requests from an on-chip requester into cycles on an external memory bus. The top three address bits of a 24-bit address choose one of eight equal 2 MB regions. Each region has its own timing and width settings, and a one-hot chip select marks which region is being accessed. The controller splits a 16-bit request into two byte cycles when the target region is 8 bits wide. It runs 2-state or 3-state cycles. A 3-state cycle can be lengthened by a programmed wait count and by an external wait pin.

Region 0 can be used as a burst read memory. After a full-length first read, further reads that fall in the same aligned 16-byte block take only 1 or 2 states. Two optional idle states protect bus turnaround: one between reads to different regions, and one between a read and the write that follows it. An optional one-entry write buffer acknowledges a write as soon as it is accepted. Any later request then waits until the buffered write has finished on the bus.

Settings are applied as a packed vector of 6 bits per region, plus three global enables. The controller latches the settings when it accepts a request, so a change takes effect only between bus cycles.

Top module: `ext_bus_ctrl`

## Requirements
- R1: The region is address bits [23:21]. While a strobe is low, exactly one chip select is low: `cs_n[r]` for that region r. All chip selects are high when no cycle runs.
- R2: A region with its 3-state bit (bit 1 of its 6-bit setting) clear holds its strobe low for exactly 2 clock cycles per bus cycle.
- R3: A region with its 3-state bit set holds its strobe low for 3 + W cycles, where W is the wait count in setting bits [3:2]. Each extra clock during which `wait_n` is low in the second-to-last state adds one more cycle.
- R4: A word request (`sz16`=1) to a region whose width bit (bit 0) is clear runs as two byte cycles: first at the even address, carrying the high byte, then at the odd address, carrying the low byte. Both use lane [7:0], and the read result is {first byte, second byte}.
- R5: On a 16-bit region, a word uses lanes [15:0]. A byte read takes lane [15:8] at an even address and lane [7:0] at an odd address, and returns it in `rdata[7:0]` with `rdata[15:8]` zero. A byte write drives the byte on both lanes. On an 8-bit region, a byte write drives {8'h00, byte}.
- R6: If region 0 has its burst-enable bit (bit 4) set, a read to region 0 that follows a region 0 read in the same aligned 16-byte block takes 2 states if bit 5 is set and 1 state otherwise. Any other access ends the burst.
- R7: With `idle_rr_en` high, one idle cycle with all strobes and chip selects inactive comes before a read whose region differs from that of a preceding read. With the enable low, there is no idle cycle.
- R8: With `idle_wr_en` high, one idle cycle comes before a write that follows a read. With the enable low, there is no idle cycle.
- R9: With `wbuf_en` high, `ack` for a write rises one cycle after acceptance. The next request starts its bus cycle only after that write ends. Otherwise `ack` rises one cycle after the last bus state.
- R10: `rd_n` and `wr_n` are active low and never low together. `ed_oe` is high only while `wr_n` is low.
- R11: `ack` is a single-cycle pulse, and `rdata` is valid while it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Request valid; held until ack |
| we | input | 1 | 1 = write, 0 = read |
| sz16 | input | 1 | 1 = 16-bit access (address forced even), 0 = byte |
| addr | input | 24 | Request byte address |
| wdata | input | 16 | Write data; a byte uses [7:0] |
| ack | output | 1 | Completion or buffered-accept pulse |
| rdata | output | 16 | Read result |
| region_cfg | input | 48 | Six setting bits per region, region r at [6r+5:6r] |
| idle_rr_en | input | 1 | Enable idle cycle between reads of different regions |
| idle_wr_en | input | 1 | Enable idle cycle for a write after a read |
| wbuf_en | input | 1 | Enable the write buffer |
| ea | output | 24 | External address |
| ed_out | output | 16 | External write data |
| ed_oe | output | 1 | External data output enable |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| cs_n | output | 8 | Region chip selects, active low |
| ed_in | input | 16 | External read data |
| wait_n | input | 1 | External wait, active low |

## Verification
Some properties are checked on every clock: strobe exclusivity and output-enable gating, the chip select agreeing with the decoded address, the quiet idle cycle, the odd address of the second split beat, the wait hold and the single-cycle acknowledge. Other behaviour needs history across several accesses, so only the bench scenarios show it. This covers cycle lengths per region setting, burst shortening and burst ending, idle insertion that depends on the previous access, byte-lane data and the stall behind a buffered write. The bench compares these against a model it keeps of the last access and the burst block.

// File: rtl/ebc_pkg.sv
package ebc_pkg;

    localparam int WAIT_W = 2;
    localparam int LEN_W  = WAIT_W + 2;

    typedef struct packed {
        logic              burst_two;
        logic              burst_en;
        logic [WAIT_W-1:0] waits;
        logic              three_st;
        logic              wide;
    } reg_cfg_t;

    localparam int CFG_W = $bits(reg_cfg_t);

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_GAP  = 2'd1,
        ST_BUS  = 2'd2
    } bus_st_t;

    function automatic logic [LEN_W-1:0] beat_states(
        input reg_cfg_t c, input logic short_b, input logic two_b);
        if (short_b)
            return two_b ? LEN_W'(2) : LEN_W'(1);
        else if (c.three_st)
            return LEN_W'(3) + LEN_W'(c.waits);
        else
            return LEN_W'(2);
    endfunction

endpackage

// File: rtl/ebc_decode.sv
module ebc_decode
    import ebc_pkg::*;
#(
    parameter int NREG = 8,
    parameter int RB   = 3
)(
    input  logic [RB-1:0]         reg_idx,
    input  logic [NREG*CFG_W-1:0] cfg_flat,
    output reg_cfg_t              cfg_sel,
    output reg_cfg_t              cfg_zero
);
    reg_cfg_t cfg_arr [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_unpack
        assign cfg_arr[g] = reg_cfg_t'(cfg_flat[g*CFG_W +: CFG_W]);
    end

    assign cfg_sel  = cfg_arr[reg_idx];
    assign cfg_zero = cfg_arr[0];
endmodule

// File: rtl/ebc_timer.sv
module ebc_timer #(
    parameter int LW = 4
)(
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [LW-1:0] load_val,
    input  logic          run,
    input  logic          stretch,
    input  logic          wait_n,
    output logic          done
);
    logic [LW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (run && cnt != '0 && !(stretch && cnt == LW'(1) && !wait_n)) begin
            cnt <= cnt - LW'(1);
        end
    end

    assign done = run && (cnt == '0);

    AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (run && !load && stretch && cnt == LW'(1) && !wait_n) |=> (cnt == LW'(1)))
        else $error("wait pin did not hold the cycle"); // R3
endmodule

// File: rtl/ebc_lane.sv
module ebc_lane (
    input  logic        wide,
    input  logic        sz16,
    input  logic        half,
    input  logic        a0,
    input  logic [15:0] wdata,
    input  logic [15:0] ed_in,
    input  logic [15:0] rdata_q,
    output logic [15:0] ed_out,
    output logic [15:0] cap_data
);
    always_comb begin
        if (wide) begin
            ed_out = sz16 ? wdata : {wdata[7:0], wdata[7:0]};
        end else if (sz16) begin
            ed_out = {8'h00, half ? wdata[7:0] : wdata[15:8]};
        end else begin
            ed_out = {8'h00, wdata[7:0]};
        end
    end

    always_comb begin
        if (wide && sz16) begin
            cap_data = ed_in;
        end else if (wide) begin
            cap_data = {8'h00, a0 ? ed_in[7:0] : ed_in[15:8]};
        end else if (sz16) begin
            cap_data = half ? {rdata_q[15:8], ed_in[7:0]} : {ed_in[7:0], 8'h00};
        end else begin
            cap_data = {8'h00, ed_in[7:0]};
        end
    end
endmodule

// File: rtl/ext_bus_ctrl.sv
module ext_bus_ctrl
    import ebc_pkg::*;
#(
    parameter int NREG      = 8,
    parameter int AW        = 24,
    parameter int BLK_BITS  = 4
)(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  req,
    input  logic                  we,
    input  logic                  sz16,
    input  logic [AW-1:0]         addr,
    input  logic [15:0]           wdata,
    output logic                  ack,
    output logic [15:0]           rdata,
    input  logic [NREG*CFG_W-1:0] region_cfg,
    input  logic                  idle_rr_en,
    input  logic                  idle_wr_en,
    input  logic                  wbuf_en,
    output logic [AW-1:0]         ea,
    output logic [15:0]           ed_out,
    output logic                  ed_oe,
    output logic                  rd_n,
    output logic                  wr_n,
    output logic [NREG-1:0]       cs_n,
    input  logic [15:0]           ed_in,
    input  logic                  wait_n
);
    localparam int RB = $clog2(NREG);
    localparam int LW = LEN_W;

    bus_st_t            st;
    logic               x_we, x_sz;
    logic [AW-1:0]      x_addr;
    logic [15:0]        x_wd;
    logic [RB-1:0]      cur_reg, last_reg;
    logic               wide_q, stretch_q, split_q, half, buffered, burst_en_q;
    logic [LW-1:0]      len_q;
    logic               ack_q, last_rd, burst_live;
    logic [AW-BLK_BITS-1:0] burst_blk;
    logic [15:0]        rdata_q, cap_data;

    reg_cfg_t           req_cfg, cfg0;
    logic [RB-1:0]      req_reg;
    logic               accept, hit_burst, need_gap, beat_done, t_load;
    logic [LW-1:0]      len_acc, t_val;
    logic [AW-1:0]      a_eff;
    logic               bus;
    logic [NREG-1:0]    cs_hot;

    assign req_reg = addr[AW-1 -: RB];

    ebc_decode #(.NREG(NREG), .RB(RB)) u_decode (
        .reg_idx  (req_reg),
        .cfg_flat (region_cfg),
        .cfg_sel  (req_cfg),
        .cfg_zero (cfg0)
    );

    assign accept    = (st == ST_IDLE) && req && !ack_q;
    assign a_eff     = sz16 ? {addr[AW-1:1], 1'b0} : addr;
    assign hit_burst = !we && (req_reg == '0) && cfg0.burst_en && burst_live
                       && (addr[AW-1:BLK_BITS] == burst_blk);
    assign len_acc   = beat_states(req_cfg, hit_burst, cfg0.burst_two);
    assign need_gap  = last_rd && ((idle_rr_en && !we && req_reg != last_reg)
                                   || (idle_wr_en && we));

    assign t_load = accept || (beat_done && split_q && !half);
    assign t_val  = accept ? (len_acc - LW'(1)) : (len_q - LW'(1));

    ebc_timer #(.LW(LW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (t_load),
        .load_val (t_val),
        .run      (bus),
        .stretch  (stretch_q),
        .wait_n   (wait_n),
        .done     (beat_done)
    );

    ebc_lane u_lane (
        .wide     (wide_q),
        .sz16     (x_sz),
        .half     (half),
        .a0       (x_addr[0]),
        .wdata    (x_wd),
        .ed_in    (ed_in),
        .rdata_q  (rdata_q),
        .ed_out   (ed_out),
        .cap_data (cap_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= ST_IDLE;
            x_we       <= 1'b0;
            x_sz       <= 1'b0;
            x_addr     <= '0;
            x_wd       <= '0;
            cur_reg    <= '0;
            last_reg   <= '0;
            wide_q     <= 1'b0;
            stretch_q  <= 1'b0;
            split_q    <= 1'b0;
            half       <= 1'b0;
            buffered   <= 1'b0;
            burst_en_q <= 1'b0;
            len_q      <= '0;
            ack_q      <= 1'b0;
            last_rd    <= 1'b0;
            burst_live <= 1'b0;
            burst_blk  <= '0;
            rdata_q    <= '0;
        end else begin
            if (ack_q) ack_q <= 1'b0;
            unique case (st)
                ST_IDLE: begin
                    if (accept) begin
                        x_we       <= we;
                        x_sz       <= sz16;
                        x_addr     <= a_eff;
                        x_wd       <= wdata;
                        cur_reg    <= req_reg;
                        wide_q     <= req_cfg.wide;
                        stretch_q  <= req_cfg.three_st && !hit_burst;
                        split_q    <= sz16 && !req_cfg.wide;
                        len_q      <= len_acc;
                        half       <= 1'b0;
                        burst_en_q <= cfg0.burst_en;
                        buffered   <= we && wbuf_en;
                        if (we && wbuf_en) ack_q <= 1'b1;
                        st <= need_gap ? ST_GAP : ST_BUS;
                    end
                end
                ST_GAP: st <= ST_BUS;
                ST_BUS: begin
                    if (beat_done) begin
                        if (!x_we) rdata_q <= cap_data;
                        if (split_q && !half) begin
                            half <= 1'b1;
                        end else begin
                            st         <= ST_IDLE;
                            ack_q      <= !buffered;
                            last_rd    <= !x_we;
                            last_reg   <= cur_reg;
                            burst_live <= !x_we && (cur_reg == '0) && burst_en_q;
                            burst_blk  <= x_addr[AW-1:BLK_BITS];
                        end
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign bus    = (st == ST_BUS);
    assign cs_hot = NREG'(1) << cur_reg;
    assign ea     = {x_addr[AW-1:1], x_addr[0] | half};
    assign rd_n   = !(bus && !x_we);
    assign wr_n   = !(bus && x_we);
    assign ed_oe  = bus && x_we;
    assign cs_n   = bus ? ~cs_hot : '1;
    assign ack    = ack_q;
    assign rdata  = rdata_q;

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(!rd_n && !wr_n))
        else $error("both strobes low"); // R10

    AST_OE_WRITE_ONLY: assert property (@(posedge clk) disable iff (rst)
        ed_oe |-> (!wr_n && rd_n))
        else $error("data enable outside a write"); // R10

    AST_CS_DECODE: assert property (@(posedge clk) disable iff (rst)
        (!rd_n || !wr_n) |-> ($countones(~cs_n) == 1 && !cs_n[ea[AW-1 -: RB]]))
        else $error("chip select does not match address"); // R1

    AST_CS_QUIET: assert property (@(posedge clk) disable iff (rst)
        (rd_n && wr_n) |-> (cs_n == '1))
        else $error("chip select active without strobe"); // R1

    AST_GAP_QUIET: assert property (@(posedge clk) disable iff (rst)
        (st == ST_GAP) |-> (rd_n && wr_n && cs_n == '1))
        else $error("idle cycle not quiet"); // R7

    AST_SPLIT_NEXT: assert property (@(posedge clk) disable iff (rst)
        (bus && half && !$past(half)) |-> (ea == $past(ea) + AW'(1)))
        else $error("second byte cycle address wrong"); // R4

    AST_ACK_PULSE: assert property (@(posedge clk) disable iff (rst)
        ack |=> !ack)
        else $error("ack longer than one cycle"); // R11
endmodule

// File: tb/ext_bus_ctrl_test.sv
module ext_bus_ctrl_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req = 1'b0, we = 1'b0, sz16 = 1'b0;
    logic [23:0] addr = '0;
    logic [15:0] wdata = '0;
    logic        ack;
    logic [15:0] rdata;
    logic [47:0] cfg_flat = '0;
    logic        idle_rr = 1'b0, idle_wr = 1'b0, wbuf = 1'b0;
    logic [23:0] ea;
    logic [15:0] ed_out, ed_in;
    logic        ed_oe, rd_n, wr_n, wait_n = 1'b1;
    logic [7:0]  cs_n;

    int checks = 0, failures = 0, cycles = 0;

    ext_bus_ctrl uut (
        .clk(clk), .rst(rst), .req(req), .we(we), .sz16(sz16), .addr(addr),
        .wdata(wdata), .ack(ack), .rdata(rdata), .region_cfg(cfg_flat),
        .idle_rr_en(idle_rr), .idle_wr_en(idle_wr), .wbuf_en(wbuf),
        .ea(ea), .ed_out(ed_out), .ed_oe(ed_oe), .rd_n(rd_n), .wr_n(wr_n),
        .cs_n(cs_n), .ed_in(ed_in), .wait_n(wait_n)
    );

    always #10 clk = ~clk;

    function automatic logic [7:0] mb(input logic [23:0] x);
        return x[7:0] ^ x[15:8] ^ x[23:16] ^ 8'h3C;
    endfunction

    always_comb begin
        logic [5:0] c;
        c = cfg_flat[ea[23:21]*6 +: 6];
        if (c[0]) ed_in = {mb({ea[23:1], 1'b0}), mb({ea[23:1], 1'b1})};
        else      ed_in = {8'hA5, mb(ea)};
    end

    task automatic chk(input string tag, input logic ok, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // bus monitor
    int          nb, pre, run_len, wait_lim, viol;
    logic        arm, seen, in_beat;
    logic [23:0] last_ea;
    logic [23:0] b_ea  [0:3];
    int          b_len [0:3];
    logic [15:0] b_do  [0:3];
    logic [7:0]  b_cs  [0:3];
    logic        b_wr  [0:3];

    initial begin
        nb = 0; pre = 0; run_len = 0; wait_lim = 0; viol = 0;
        arm = 0; seen = 0; in_beat = 0; last_ea = '0;
    end

    always @(negedge clk) begin
        if (ed_oe && wr_n) viol++;
        if (!rd_n && !wr_n) viol++;
        if (!rd_n || !wr_n) begin
            run_len++;
            if (!in_beat || ea != last_ea) begin
                if (nb < 4) begin
                    b_ea[nb] = ea; b_len[nb] = 1; b_do[nb] = ed_out;
                    b_cs[nb] = cs_n; b_wr[nb] = !wr_n;
                end
                nb++;
            end else if (nb >= 1 && nb <= 4) begin
                b_len[nb-1]++;
            end
            in_beat = 1; last_ea = ea; seen = 1;
            wait_n <= !(run_len <= wait_lim);
        end else begin
            in_beat = 0; run_len = 0;
            wait_n <= 1'b1;
            if (arm && !seen) pre++;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            failures++;
            $display("FAIL R11 watchdog act=%0d exp=%0d", cycles, 150000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // reference model state
    logic        m_live = 0, m_lastrd = 0;
    logic [19:0] m_blk = '0;
    int          m_lastreg = 0;

    task automatic run_access(input logic t_we, input logic [23:0] t_a, input logic t_sz,
                              input logic [15:0] t_wd, input int t_k);
        int r, beats, L, k, gap, exp_lat, lat;
        logic [5:0] c, c0;
        logic [23:0] a;
        logic shrt, got, wide;
        logic [15:0] rd, exp_rd, exp_do;
        r = int'(t_a[23:21]);
        c = cfg_flat[r*6 +: 6];
        c0 = cfg_flat[5:0];
        a = t_sz ? {t_a[23:1], 1'b0} : t_a;
        wide = c[0];
        beats = (t_sz && !wide) ? 2 : 1;
        shrt = !t_we && r == 0 && c0[4] && m_live && a[23:4] == m_blk;
        L = shrt ? (c0[5] ? 2 : 1) : (c[1] ? 3 + int'(c[3:2]) : 2);
        k = (beats == 1 && c[1] && !shrt) ? t_k : 0;
        gap = (m_lastrd && ((idle_rr && !t_we && r != m_lastreg) || (idle_wr && t_we))) ? 1 : 0;
        exp_lat = (t_we && wbuf) ? 1 : gap + beats * L + k + 1;
        if (wide) exp_rd = t_sz ? {mb(a), mb(a + 24'd1)} : {8'h00, mb(a)};
        else      exp_rd = t_sz ? {mb(a), mb(a + 24'd1)} : {8'h00, mb(a)};

        @(negedge clk); #1;
        nb = 0; pre = 0; seen = 0; arm = 1;
        wait_lim = (k > 0) ? L - 2 + k : 0;
        we = t_we; addr = t_a; sz16 = t_sz; wdata = t_wd; req = 1'b1;
        lat = 0; got = 0; rd = '0;
        while (!got && lat < 40) begin
            @(negedge clk); #1;
            lat++;
            if (ack) begin got = 1; rd = rdata; end
        end
        req = 1'b0;
        @(negedge clk); #1;
        chk("R11 ack pulse", !ack, 32'(ack), 0);
        repeat (16) @(negedge clk);
        #1; arm = 0; wait_lim = 0;

        chk("R9 ack timing", lat == exp_lat, 32'(lat), 32'(exp_lat));
        chk("R7 R8 idle cycles", pre == gap, 32'(pre), 32'(gap));
        chk("R4 beat count", nb == beats, 32'(nb), 32'(beats));
        for (int i = 0; i < beats && i < nb; i++) begin
            chk("R4 beat address", b_ea[i] == a + 24'(i), 32'(b_ea[i]), 32'(a + 24'(i)));
            chk("R2 R3 R6 beat length", b_len[i] == L + ((i == 0) ? k : 0),
                32'(b_len[i]), 32'(L + ((i == 0) ? k : 0)));
            chk("R1 chip select", b_cs[i] == ~(8'b1 << r), 32'(b_cs[i]), 32'(~(8'b1 << r)));
            chk("R10 strobe kind", b_wr[i] == t_we, 32'(b_wr[i]), 32'(t_we));
            if (t_we) begin
                if (wide) exp_do = t_sz ? t_wd : {t_wd[7:0], t_wd[7:0]};
                else      exp_do = {8'h00, t_sz ? ((i == 0) ? t_wd[15:8] : t_wd[7:0]) : t_wd[7:0]};
                chk("R5 write lanes", b_do[i] == exp_do, 32'(b_do[i]), 32'(exp_do));
            end
        end
        if (!t_we) chk("R5 R11 read data", rd == exp_rd, 32'(rd), 32'(exp_rd));
        chk("R10 strobe and enable rules", viol == 0, 32'(viol), 0);

        m_lastrd = !t_we; m_lastreg = r;
        m_live = !t_we && r == 0 && c0[4];
        m_blk = a[23:4];
    endtask

    function automatic logic [5:0] mk(input logic wd, input logic t3, input int w,
                                      input logic be, input logic b2);
        return {b2, be, 2'(w), t3, wd};
    endfunction

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        #1; rst = 1'b0;
        @(negedge clk); #1;
        chk("R10 reset strobes", rd_n && wr_n && !ed_oe, {29'd0, rd_n, wr_n, ed_oe}, 32'h6);
        chk("R1 reset chip selects", cs_n == 8'hFF, 32'(cs_n), 32'hFF);
        chk("R11 reset ack", !ack, 32'(ack), 0);

        // region 0: 16-bit, 3-state, 1 wait, burst 1-state; region 2: 16-bit 2-state
        // region 3: 8-bit 3-state 2 waits; region 5: 16-bit 3-state 3 waits
        cfg_flat = '0;
        cfg_flat[0*6 +: 6] = mk(1, 1, 1, 1, 0);
        cfg_flat[1*6 +: 6] = mk(0, 0, 0, 0, 0);
        cfg_flat[2*6 +: 6] = mk(1, 0, 0, 0, 0);
        cfg_flat[3*6 +: 6] = mk(0, 1, 2, 0, 0);
        cfg_flat[4*6 +: 6] = mk(1, 1, 0, 0, 0);
        cfg_flat[5*6 +: 6] = mk(1, 1, 3, 0, 0);

        // R2 and R5: 16-bit 2-state region
        run_access(0, 24'h400020, 1, 16'h0, 0);
        run_access(0, 24'h400022, 0, 16'h0, 0);
        run_access(0, 24'h400023, 0, 16'h0, 0);
        run_access(1, 24'h400031, 0, 16'h00C7, 0);
        run_access(1, 24'h400040, 1, 16'hBEEF, 0);
        // R3 and R4: 8-bit region, split and waits
        run_access(0, 24'h600010, 1, 16'h0, 0);
        run_access(1, 24'h600018, 1, 16'h1234, 0);
        run_access(0, 24'h600005, 0, 16'h0, 2);
        run_access(0, 24'h800004, 0, 16'h0, 3);
        // R7 and R8: idle insertion on and off
        idle_rr = 1; idle_wr = 1;
        run_access(0, 24'h200000, 0, 16'h0, 0);
        run_access(0, 24'h800000, 0, 16'h0, 0);
        run_access(0, 24'h800002, 0, 16'h0, 0);
        run_access(1, 24'h800004, 1, 16'h5A5A, 0);
        run_access(0, 24'h200000, 0, 16'h0, 0);
        idle_rr = 0; idle_wr = 0;
        run_access(0, 24'h400000, 0, 16'h0, 0);
        run_access(1, 24'h400000, 0, 16'h0011, 0);
        // R6: burst on region 0
        run_access(0, 24'h000000, 1, 16'h0, 0);
        run_access(0, 24'h000002, 1, 16'h0, 0);
        run_access(0, 24'h000007, 0, 16'h0, 0);
        run_access(0, 24'h000010, 1, 16'h0, 0);
        run_access(1, 24'h000012, 1, 16'h7777, 0);
        run_access(0, 24'h000014, 1, 16'h0, 0);
        cfg_flat[0*6 +: 6] = mk(1, 1, 1, 1, 1);
        run_access(0, 24'h000016, 1, 16'h0, 0);

        // R9: buffered write stalls the next request
        begin
            int n, first_rd, wr_cnt;
            logic a1;
            wbuf = 1;
            @(negedge clk); #1;
            we = 1; sz16 = 1; addr = 24'hA00000; wdata = 16'hCAFE; req = 1;
            n = 0; first_rd = 0; wr_cnt = 0; a1 = 0;
            while (first_rd == 0 && n < 40) begin
                @(negedge clk);
                n++;
                if (!wr_n) wr_cnt++;
                if (!rd_n) first_rd = n;
                if (n == 1) a1 = ack;
                #1;
                if (n == 1) begin we = 0; addr = 24'h400010; end
            end
            chk("R9 early write ack", a1, 32'(a1), 1);
            chk("R9 buffered write length", wr_cnt == 6, 32'(wr_cnt), 6);
            chk("R9 stalled read start", first_rd == 8, 32'(first_rd), 8);
            while (!ack && n < 60) begin @(negedge clk); #1; n++; end
            req = 0;
            repeat (16) @(negedge clk);
            #1;
            m_lastrd = 1; m_lastreg = 2; m_live = 0;
            wbuf = 0;
        end

        // constrained random mix
        for (int it = 0; it < 300; it++) begin
            logic [23:0] ra;
            if (it % 8 == 0) begin
                cfg_flat = {16'($urandom), $urandom};
                idle_rr = 1'($urandom); idle_wr = 1'($urandom); wbuf = 1'($urandom);
            end
            ra = 24'($urandom % 40);
            ra[23:21] = ($urandom % 3 == 0) ? 3'd0 : 3'($urandom);
            run_access(1'($urandom), ra, 1'($urandom), 16'($urandom), int'($urandom % 3));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule